// File: doc/BRIEF.md
# Message-Signalled Interrupt Forwarding Scanner

This block sits between the per-source interrupt state of an interrupt domain and the fabric that delivers message-signalled interrupts to harts. On every cycle it looks at the pending and enable bits of all sources. While the domain's interrupt-enable input is high, it takes the lowest-numbered source that has both bits set and loads a message for it into a single output slot. The message carries a hart index, a guest index and an interrupt identity, all cut from that source's 32-bit target word. In the same cycle it raises a one-hot clear pulse so that the state logic drops that source's pending bit.

A software message register shares the output slot. A write to it loads a message with the written hart index and identity and a guest index of zero. This message does not depend on the domain enable, and it takes the slot ahead of any source. A busy flag stays high until the fabric accepts that message. Messages leave through a valid/ready handshake. The slot reloads in the same cycle that its current message is accepted, so one message can go out per cycle.

Top module: `msi_fwd_scanner`

## Requirements
- R1: Synchronous active-high reset: after reset, `msg_valid_o`, `sw_busy_o` and `sw_val_o` read 0. `clr_pend_o` is 0 while the inputs are quiet.
- R2: While `dom_en_i` is low, no source message is loaded and `clr_pend_o` stays 0. Pending bits are therefore kept.
- R3: A source is forwarded only when its bit in `src_en_i` and its bit in `src_pend_i` are both 1.
- R4: `clr_pend_o` is one-hot or zero. It has a source's bit set exactly in the cycle when that source's message is loaded into the slot, which is the cycle before `msg_valid_o` presents it.
- R5: Source k's target word is `src_tgt_i[32k+31:32k]`. Its message has hart index = bits 31:18, guest index = bits 17:12 and identity = bits 10:0, and `msg_src_o` = k.
- R6: Among the eligible sources, the lowest-numbered one is loaded first. At most one message is loaded per cycle. The slot loads whenever it is empty or its message is accepted in that cycle.
- R7: While `msg_valid_o` is high and `msg_ready_i` is low, all message outputs hold their values, nothing is loaded and `clr_pend_o` is 0.
- R8: A software message has hart index = `sw_val_o[31:18]`, identity = `sw_val_o[10:0]`, guest index 0 and `msg_src_o` = 0. It is loaded regardless of `dom_en_i`, and it wins over any source in the same cycle.
- R9: A `sw_wr_i` pulse while `sw_busy_o` is low stores `sw_wdata_i` with bits 17:12 cleared. `sw_busy_o` then goes high on the next cycle and drops on the cycle after the software message is accepted. A write while `sw_busy_o` is high is ignored.
- R10: Bit 0 of `src_pend_i` and `src_en_i` is never forwarded or cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| dom_en_i | input | 1 | Domain interrupt enable; gates source forwarding |
| src_pend_i | input | NUM_SRC+1 | Pending bit per source, bit 0 unused |
| src_en_i | input | NUM_SRC+1 | Enable bit per source, bit 0 unused |
| src_tgt_i | input | 32*(NUM_SRC+1) | Target word per source, source k at bits 32k+31:32k |
| sw_wr_i | input | 1 | Write strobe for the software message register |
| sw_wdata_i | input | 32 | Write data for the software message register |
| sw_val_o | output | 32 | Stored software message value, guest field cleared |
| sw_busy_o | output | 1 | Software message waiting or in flight |
| msg_valid_o | output | 1 | Output message valid |
| msg_ready_i | input | 1 | Output message accepted when high with valid |
| msg_hart_o | output | 14 | Hart index of the message |
| msg_guest_o | output | 6 | Guest index of the message |
| msg_id_o | output | 11 | Interrupt identity of the message |
| msg_src_o | output | SRC_W | Source number, 0 for a software message |
| clr_pend_o | output | NUM_SRC+1 | One-hot pulse that clears the forwarded source's pending bit |

## Verification
Two functions can compete for the one output slot in the same cycle. One is a software message that is waiting. The other is an eligible source whose clear pulse would be raised if it won. The bench provokes this by stalling the slot with `msg_ready_i` low, writing the software register, setting pending sources, and then raising ready. The software message must win, and no clear pulse may appear in that cycle. A second overlap is an acceptance together with a reload, where the next source's clear pulse fires in the same cycle as the handshake. A behavioural model predicts the slot contents, the busy flag and the exact clear mask for every cycle, and compares them with the outputs.

// File: rtl/msi_fwd_pkg.sv
package msi_fwd_pkg;

    localparam int TGT_W     = 32;
    localparam int HART_W    = 14;
    localparam int HART_LSB  = 18;
    localparam int GUEST_W   = 6;
    localparam int GUEST_LSB = 12;
    localparam int ID_W      = 11;
    localparam int ID_LSB    = 0;
    localparam int RSVD_BIT  = 11;

    typedef struct packed {
        logic [HART_W-1:0]  hart;
        logic [GUEST_W-1:0] guest;
        logic [ID_W-1:0]    id;
    } msi_msg_t;

    // Clear the guest field of a raw register value.
    function automatic logic [TGT_W-1:0] scrub_guest(input logic [TGT_W-1:0] raw);
        logic [TGT_W-1:0] v;
        v = raw;
        v[GUEST_LSB +: GUEST_W] = '0;
        return v;
    endfunction

endpackage

// File: rtl/msi_tgt_decode.sv
module msi_tgt_decode
    import msi_fwd_pkg::*;
#(
    parameter bit ZERO_GUEST = 1'b0
) (
    input  logic [TGT_W-1:0] raw_i,
    output msi_msg_t         msg_o
);

    logic unused_rsvd;
    assign unused_rsvd = raw_i[RSVD_BIT];

    assign msg_o.hart = raw_i[HART_LSB +: HART_W];
    assign msg_o.id   = raw_i[ID_LSB +: ID_W];

    generate
        if (ZERO_GUEST) begin : g_forced
            logic unused_guest;
            assign unused_guest = ^raw_i[GUEST_LSB +: GUEST_W];
            assign msg_o.guest  = '0;
        end else begin : g_field
            assign msg_o.guest = raw_i[GUEST_LSB +: GUEST_W];
        end
    endgenerate

endmodule

// File: rtl/msi_src_picker.sv
module msi_src_picker #(
    parameter int NUM_SRC = 15,
    parameter int SRC_W   = $clog2(NUM_SRC + 1)
) (
    input  logic               gate_i,
    input  logic [NUM_SRC:0]   pend_i,
    input  logic [NUM_SRC:0]   en_i,
    output logic               found_o,
    output logic [SRC_W-1:0]   idx_o,
    output logic [NUM_SRC:0]   grant_o
);

    localparam logic [NUM_SRC:0] LIVE_MASK = {{NUM_SRC{1'b1}}, 1'b0};

    logic [NUM_SRC:0]   req;
    logic [NUM_SRC+1:0] seen;

    assign req     = pend_i & en_i & LIVE_MASK & {(NUM_SRC + 1){gate_i}};
    assign seen[0] = 1'b0;

    generate
        for (genvar gi = 0; gi <= NUM_SRC; gi++) begin : g_chain
            assign grant_o[gi]  = req[gi] & ~seen[gi];
            assign seen[gi + 1] = seen[gi] | req[gi];
        end
    endgenerate

    assign found_o = seen[NUM_SRC + 1];

    always_comb begin
        idx_o = '0;
        for (int k = 0; k <= NUM_SRC; k++) begin
            if (grant_o[k]) begin
                idx_o = idx_o | SRC_W'(k);
            end
        end
    end

endmodule

// File: rtl/msi_sw_reg.sv
module msi_sw_reg
    import msi_fwd_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_i,
    input  logic [TGT_W-1:0] wdata_i,
    input  logic             take_i,
    input  logic             done_i,
    output logic [TGT_W-1:0] val_o,
    output logic             busy_o,
    output logic             req_o
);

    logic in_slot;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            val_o   <= '0;
            busy_o  <= 1'b0;
            in_slot <= 1'b0;
        end else begin
            if (wr_i && !busy_o) begin
                val_o  <= scrub_guest(wdata_i);
                busy_o <= 1'b1;
            end
            if (take_i) begin
                in_slot <= 1'b1;
            end
            if (done_i) begin
                busy_o  <= 1'b0;
                in_slot <= 1'b0;
            end
        end
    end

    assign req_o = busy_o & ~in_slot;

endmodule

// File: rtl/msi_out_slot.sv
module msi_out_slot
    import msi_fwd_pkg::*;
#(
    parameter int SRC_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  msi_msg_t         load_msg_i,
    input  logic [SRC_W-1:0] load_src_i,
    input  logic             ready_i,
    output logic             valid_o,
    output msi_msg_t         msg_o,
    output logic [SRC_W-1:0] src_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_o <= 1'b0;
            msg_o   <= '0;
            src_o   <= '0;
        end else if (load_i) begin
            valid_o <= 1'b1;
            msg_o   <= load_msg_i;
            src_o   <= load_src_i;
        end else if (ready_i) begin
            valid_o <= 1'b0;
        end
    end

endmodule

// File: rtl/msi_fwd_scanner.sv
module msi_fwd_scanner
    import msi_fwd_pkg::*;
#(
    parameter  int NUM_SRC = 15,
    localparam int SRC_W   = $clog2(NUM_SRC + 1)
) (
    input  logic                           clk_i,
    input  logic                           rst_i,
    input  logic                           dom_en_i,
    input  logic [NUM_SRC:0]               src_pend_i,
    input  logic [NUM_SRC:0]               src_en_i,
    input  logic [(NUM_SRC+1)*TGT_W-1:0]   src_tgt_i,
    input  logic                           sw_wr_i,
    input  logic [TGT_W-1:0]               sw_wdata_i,
    output logic [TGT_W-1:0]               sw_val_o,
    output logic                           sw_busy_o,
    output logic                           msg_valid_o,
    input  logic                           msg_ready_i,
    output logic [HART_W-1:0]              msg_hart_o,
    output logic [GUEST_W-1:0]             msg_guest_o,
    output logic [ID_W-1:0]                msg_id_o,
    output logic [SRC_W-1:0]               msg_src_o,
    output logic [NUM_SRC:0]               clr_pend_o
);

    logic             pick_found;
    logic [SRC_W-1:0] pick_idx;
    logic [NUM_SRC:0] pick_grant;
    logic [TGT_W-1:0] sel_tgt;
    msi_msg_t         src_msg;
    msi_msg_t         sw_msg;
    msi_msg_t         load_msg;
    logic [SRC_W-1:0] load_src;
    logic             sw_req;
    logic             slot_valid;
    msi_msg_t         slot_msg;
    logic [SRC_W-1:0] slot_src;
    logic             slot_free;
    logic             take_sw;
    logic             take_src;
    logic             sw_done;

    msi_src_picker #(
        .NUM_SRC (NUM_SRC),
        .SRC_W   (SRC_W)
    ) u_pick (
        .gate_i  (dom_en_i),
        .pend_i  (src_pend_i),
        .en_i    (src_en_i),
        .found_o (pick_found),
        .idx_o   (pick_idx),
        .grant_o (pick_grant)
    );

    assign sel_tgt = src_tgt_i[pick_idx * TGT_W +: TGT_W];

    msi_tgt_decode #(.ZERO_GUEST(1'b0)) u_dec_src (
        .raw_i (sel_tgt),
        .msg_o (src_msg)
    );

    msi_tgt_decode #(.ZERO_GUEST(1'b1)) u_dec_sw (
        .raw_i (sw_val_o),
        .msg_o (sw_msg)
    );

    msi_sw_reg u_sw (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_i    (sw_wr_i),
        .wdata_i (sw_wdata_i),
        .take_i  (take_sw),
        .done_i  (sw_done),
        .val_o   (sw_val_o),
        .busy_o  (sw_busy_o),
        .req_o   (sw_req)
    );

    // Slot arbitration: a waiting software message goes ahead of the sources.
    assign slot_free = ~slot_valid | msg_ready_i;
    assign take_sw   = slot_free & sw_req;
    assign take_src  = slot_free & ~sw_req & pick_found;
    assign load_msg  = take_sw ? sw_msg : src_msg;
    assign load_src  = take_sw ? '0 : pick_idx;
    assign sw_done   = slot_valid & msg_ready_i & (slot_src == '0);

    msi_out_slot #(.SRC_W(SRC_W)) u_slot (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (take_sw | take_src),
        .load_msg_i (load_msg),
        .load_src_i (load_src),
        .ready_i    (msg_ready_i),
        .valid_o    (slot_valid),
        .msg_o      (slot_msg),
        .src_o      (slot_src)
    );

    assign clr_pend_o  = take_src ? pick_grant : '0;
    assign msg_valid_o = slot_valid;
    assign msg_hart_o  = slot_msg.hart;
    assign msg_guest_o = slot_msg.guest;
    assign msg_id_o    = slot_msg.id;
    assign msg_src_o   = slot_src;

endmodule

// File: rtl/msi_fwd_checker.sv
module msi_fwd_checker
    import msi_fwd_pkg::*;
#(
    parameter  int NUM_SRC = 15,
    localparam int SRC_W   = $clog2(NUM_SRC + 1)
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               dom_en_i,
    input logic [NUM_SRC:0]   src_pend_i,
    input logic [NUM_SRC:0]   src_en_i,
    input logic               sw_busy_o,
    input logic               msg_valid_o,
    input logic               msg_ready_i,
    input logic [HART_W-1:0]  msg_hart_o,
    input logic [GUEST_W-1:0] msg_guest_o,
    input logic [ID_W-1:0]    msg_id_o,
    input logic [SRC_W-1:0]   msg_src_o,
    input logic [NUM_SRC:0]   clr_pend_o
);

    // R2
    dom_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !dom_en_i |-> clr_pend_o == '0);

    // R3
    clr_elig_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_pend_o & ~(src_en_i & src_pend_i)) == '0);

    // R4
    clr_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(clr_pend_o));

    // R4
    clr_issue_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_pend_o != '0) |=> msg_valid_o && (msg_src_o != '0));

    // R7
    hold_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_hart_o) &&
        $stable(msg_guest_o) && $stable(msg_id_o) && $stable(msg_src_o));

    // R7
    stall_noclr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        msg_valid_o && !msg_ready_i |-> clr_pend_o == '0);

    // R8
    sw_guest_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        msg_valid_o && (msg_src_o == '0) |-> msg_guest_o == '0);

    // R9
    busy_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        sw_busy_o && !(msg_valid_o && msg_ready_i && (msg_src_o == '0)) |=> sw_busy_o);

    // R10
    src0_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !clr_pend_o[0]);

endmodule

bind msi_fwd_scanner msi_fwd_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .dom_en_i    (dom_en_i),
    .src_pend_i  (src_pend_i),
    .src_en_i    (src_en_i),
    .sw_busy_o   (sw_busy_o),
    .msg_valid_o (msg_valid_o),
    .msg_ready_i (msg_ready_i),
    .msg_hart_o  (msg_hart_o),
    .msg_guest_o (msg_guest_o),
    .msg_id_o    (msg_id_o),
    .msg_src_o   (msg_src_o),
    .clr_pend_o  (clr_pend_o)
);

// File: tb/sim_msi_fwd_scanner.sv
module sim_msi_fwd_scanner;

    localparam int NS = 15;
    localparam int SW = $clog2(NS + 1);

    logic              clk = 1'b0;
    logic              rst;
    logic              dom_en;
    logic [NS:0]       pend = '0;
    logic [NS:0]       en;
    logic [(NS+1)*32-1:0] tgt;
    logic              sw_wr;
    logic [31:0]       sw_wdata;
    logic [31:0]       sw_val;
    logic              sw_busy;
    logic              msg_valid;
    logic              msg_ready;
    logic [13:0]       msg_hart;
    logic [5:0]        msg_guest;
    logic [10:0]       msg_id;
    logic [SW-1:0]     msg_src;
    logic [NS:0]       clr_pend;

    always #5 clk = ~clk;

    msi_fwd_scanner #(.NUM_SRC(NS)) u0 (
        .clk_i       (clk),
        .rst_i       (rst),
        .dom_en_i    (dom_en),
        .src_pend_i  (pend),
        .src_en_i    (en),
        .src_tgt_i   (tgt),
        .sw_wr_i     (sw_wr),
        .sw_wdata_i  (sw_wdata),
        .sw_val_o    (sw_val),
        .sw_busy_o   (sw_busy),
        .msg_valid_o (msg_valid),
        .msg_ready_i (msg_ready),
        .msg_hart_o  (msg_hart),
        .msg_guest_o (msg_guest),
        .msg_id_o    (msg_id),
        .msg_src_o   (msg_src),
        .clr_pend_o  (clr_pend)
    );

    integer checks = 0;
    integer failures = 0;
    bit     done = 1'b0;

    // Reference model state
    bit          m_valid = 1'b0;
    logic [13:0] m_hart = '0;
    logic [5:0]  m_guest = '0;
    logic [10:0] m_id = '0;
    int          m_src = 0;
    bit          m_busy = 1'b0;
    bit          m_swin = 1'b0;
    logic [31:0] m_swq = '0;
    int          msg_cnt = 0;
    logic [NS:0] pend_set = '0;
    logic [NS:0] pend_nx = '0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Pending register owned by the bench, updated just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            pend = pend_nx;
        end
    end

    // Cycle-by-cycle comparison against the behavioural model.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            model_step();
        end
    end

    task automatic model_step();
        bit          free, sw_req, found, acc_sw;
        int          pk;
        logic [NS:0] exp_clr;
        logic [31:0] tw;
        bit          n_valid, n_busy, n_swin;
        logic [13:0] n_hart;
        logic [5:0]  n_guest;
        logic [10:0] n_id;
        int          n_src;
        logic [31:0] n_swq;
        exp_clr = '0;
        if (rst) begin
            check(msg_valid == 1'b0, "R1 valid after reset", 64'(msg_valid), 0);
            check(sw_busy == 1'b0, "R1 busy after reset", 64'(sw_busy), 0);
            check(sw_val == 32'h0, "R1 stored value after reset", 64'(sw_val), 0);
            check(clr_pend == '0, "R1 clear after reset", 64'(clr_pend), 0);
            m_valid = 1'b0; m_busy = 1'b0; m_swin = 1'b0; m_swq = '0;
            m_hart = '0; m_guest = '0; m_id = '0; m_src = 0;
            pend_nx = pend | pend_set;
            return;
        end
        check(msg_valid == m_valid, "R7 valid", 64'(msg_valid), 64'(m_valid));
        if (m_valid) begin
            check(msg_hart == m_hart, (m_src == 0) ? "R8 hart" : "R5 hart",
                  64'(msg_hart), 64'(m_hart));
            check(msg_guest == m_guest, (m_src == 0) ? "R8 guest" : "R5 guest",
                  64'(msg_guest), 64'(m_guest));
            check(msg_id == m_id, (m_src == 0) ? "R8 id" : "R5 id",
                  64'(msg_id), 64'(m_id));
            check(int'(msg_src) == m_src, "R6 source order", 64'(msg_src), 64'(m_src));
        end
        check(sw_busy == m_busy, "R9 busy", 64'(sw_busy), 64'(m_busy));
        check(sw_val == m_swq, "R9 stored value", 64'(sw_val), 64'(m_swq));

        free   = !m_valid || msg_ready;
        sw_req = m_busy && !m_swin;
        found  = 1'b0;
        pk     = 0;
        if (dom_en) begin
            for (int k = 1; k <= NS; k++) begin
                if (!found && en[k] && pend[k]) begin
                    found = 1'b1;
                    pk    = k;
                end
            end
        end
        acc_sw = m_valid && msg_ready && (m_src == 0);
        if (m_valid && msg_ready) msg_cnt++;

        n_valid = m_valid; n_hart = m_hart; n_guest = m_guest; n_id = m_id;
        n_src = m_src; n_busy = m_busy; n_swin = m_swin; n_swq = m_swq;
        if (free) begin
            if (sw_req) begin
                n_valid = 1'b1; n_hart = m_swq[31:18]; n_guest = '0;
                n_id = m_swq[10:0]; n_src = 0; n_swin = 1'b1;
            end else if (found) begin
                tw = tgt[pk*32 +: 32];
                n_valid = 1'b1; n_hart = tw[31:18]; n_guest = tw[17:12];
                n_id = tw[10:0]; n_src = pk; exp_clr[pk] = 1'b1;
            end else begin
                n_valid = 1'b0;
            end
        end
        if (acc_sw) begin
            n_busy = 1'b0;
            n_swin = 1'b0;
        end
        if (sw_wr && !m_busy) begin
            n_busy = 1'b1;
            n_swq  = sw_wdata & 32'hFFFC_0FFF;
        end
        check(clr_pend == exp_clr, dom_en ? "R3/R4 clear pulse" : "R2 clear pulse",
              64'(clr_pend), 64'(exp_clr));
        pend_nx = (pend | pend_set) & ~exp_clr;

        m_valid = n_valid; m_hart = n_hart; m_guest = n_guest; m_id = n_id;
        m_src = n_src; m_busy = n_busy; m_swin = n_swin; m_swq = n_swq;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_pend(input logic [NS:0] mask);
        @(negedge clk);
        pend_set = mask;
        @(negedge clk);
        pend_set = '0;
    endtask

    task automatic sw_write(input logic [31:0] v);
        @(negedge clk);
        sw_wr    = 1'b1;
        sw_wdata = v;
        @(negedge clk);
        sw_wr    = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            finish_run();
        end
    end

    initial begin
        int base;
        logic [31:0] rnd;
        rst = 1'b1; dom_en = 1'b0; en = '0; sw_wr = 1'b0; sw_wdata = '0;
        msg_ready = 1'b0;
        for (int k = 0; k <= NS; k++) begin
            tgt[k*32 +: 32] = {14'(k * 613 + 5), 6'(k + 40), 1'b1, 11'(k * 97 + 3)};
        end
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        // R1: quiet after reset
        check(msg_valid == 1'b0 && sw_busy == 1'b0, "R1 idle after reset",
              64'({msg_valid, sw_busy}), 0);

        // R2: domain disabled holds everything; R10: source 0 bit ignored
        msg_ready = 1'b1;
        en = 16'h0229 ;
        pulse_pend(16'h0229);
        wait_cyc(8);
        check(msg_cnt == 0, "R2 no message while domain disabled", 64'(msg_cnt), 0);
        check(pend == 16'h0229, "R2 pending kept", 64'(pend), 64'h0229);

        // R6: enable domain, expect sources 3, 5, 9 in order
        @(negedge clk);
        dom_en = 1'b1;
        wait_cyc(10);
        check(msg_cnt == 3, "R6 three sources forwarded", 64'(msg_cnt), 3);
        check(pend == 16'h0001, "R10 source 0 pending untouched", 64'(pend), 1);

        // R3: pending without enable, enable without pending
        base = msg_cnt;
        en = en | 16'h0100;
        pulse_pend(16'h0080);
        wait_cyc(6);
        check(msg_cnt == base, "R3 nothing forwarded", 64'(msg_cnt), 64'(base));
        check(pend[7] == 1'b1, "R3 pending 7 kept", 64'(pend[7]), 1);
        @(negedge clk);
        en[7] = 1'b1;
        wait_cyc(4);
        check(msg_cnt == base + 1, "R3 forwarded once enabled", 64'(msg_cnt),
              64'(base + 1));

        // R7: backpressure with several sources pending
        @(negedge clk);
        msg_ready = 1'b0;
        en = 16'hFFFE;
        pulse_pend(16'h0054);
        wait_cyc(6);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            msg_ready = i[0];
        end
        @(negedge clk);
        msg_ready = 1'b1;
        wait_cyc(4);
        check(pend == 16'h0001, "R7 all drained after stalls", 64'(pend), 1);

        // R8/R9: software message with domain disabled, write while busy
        @(negedge clk);
        dom_en = 1'b0;
        msg_ready = 1'b0;
        base = msg_cnt;
        sw_write(32'hABCD_F7FF);
        wait_cyc(2);
        check(sw_busy == 1'b1, "R9 busy while waiting", 64'(sw_busy), 1);
        sw_write(32'h1234_5678);
        check(sw_val == (32'hABCD_F7FF & 32'hFFFC_0FFF), "R9 write while busy ignored",
              64'(sw_val), 64'(32'hABCD_F7FF & 32'hFFFC_0FFF));
        @(negedge clk);
        msg_ready = 1'b1;
        wait_cyc(3);
        check(sw_busy == 1'b0, "R9 busy cleared after accept", 64'(sw_busy), 0);
        check(msg_cnt == base + 1, "R8 software message sent", 64'(msg_cnt),
              64'(base + 1));

        // R8: software message and sources compete for the slot
        @(negedge clk);
        dom_en = 1'b1;
        msg_ready = 1'b0;
        pulse_pend(16'h0C00);
        sw_write(32'h0007_F123);
        wait_cyc(2);
        @(negedge clk);
        msg_ready = 1'b1;
        wait_cyc(6);
        check(pend == 16'h0001, "R6 both sources forwarded", 64'(pend), 1);
        check(sw_busy == 1'b0, "R8 software message sent", 64'(sw_busy), 0);

        // Mixed traffic
        rnd = 32'h1ACE_B00C;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            rnd = rnd * 32'd1103515245 + 32'd12345;
            msg_ready = rnd[20] | rnd[21];
            pend_set  = (rnd[24:22] == 3'd0) ? 16'(rnd[15:0]) : '0;
            sw_wr     = (rnd[27:25] == 3'd0);
            sw_wdata  = rnd ^ 32'h5A5A_A5A5;
            if (rnd[31:28] == 4'd0) dom_en = ~dom_en;
            if (rnd[19:17] == 3'd0) en = 16'(rnd[31:16]);
        end
        @(negedge clk);
        pend_set = '0; sw_wr = 1'b0; msg_ready = 1'b1; dom_en = 1'b1; en = 16'hFFFF;
        wait_cyc(30);
        check(pend == (pend & 16'h0001), "R10 drained except source 0",
              64'(pend), 64'(pend & 16'h0001));
        check(msg_valid == 1'b0, "R6 slot empty after drain", 64'(msg_valid), 0);
        finish_run();
    end

endmodule